// File: doc/BRIEF.md
# DMA Cycle-Steal Bus-Mode Sequencer

This block decides when one DMA channel takes the system bus and when it gives it back. A start pulse loads a mode, a transfer-unit size and a unit count while the channel is idle. The channel then waits for an active-low, level-sensitive transfer request. When the request is present, it raises a bus request toward a simple arbiter. Once the grant arrives, it performs dual-address transfers. Each beat is a read strobe cycle followed by a write strobe cycle.

Four bus modes are supported. In burst mode the bus stays held across units for as long as the request remains low. Normal cycle-steal mode releases the bus after every unit. The two throttled cycle-steal modes also insert a fixed idle gap of 16 or 64 clocks before every unit after the first. The count is decremented at each unit end. When it reaches zero, a sticky done flag rises and the bus is not requested again until the next start. Addresses and data are not modelled.

Top module: `dma_steal_seq`

## Requirements
- R1: After reset, bus_req, rd_stb, wr_stb and done are all low. The mode field is encoded as follows: 0 = burst, 1 = normal cycle-steal, 2 = throttled with a 16-clock gap, 3 = throttled with a 64-clock gap.
- R2: A start pulse while idle latches the mode, size and count. A start with count 0 raises done on the next cycle and never raises bus_req.
- R3: While the channel is armed and req_n is high, bus_req stays low. A low level on req_n is what counts as a request.
- R4: bus_req rises one cycle after a low req_n is sampled while armed (first unit, or non-throttled modes). While bus_gnt is low, bus_req holds and rd_stb stays low. rd_stb rises in the cycle after bus_gnt is sampled high.
- R5: Each beat is exactly one rd_stb cycle followed directly by one wr_stb cycle. The two strobes are never high together, and bus_req is high throughout the beat.
- R6: The size field is encoded as follows: 0 = byte, 1 = word, 2 = longword, 3 = 16-byte block. Sizes 0 to 2 take one beat per unit. Size 3 takes four back-to-back beats before any release.
- R7: In normal cycle-steal mode, bus_req drops after every unit, so each unit has its own bus_req assertion.
- R8: In throttled modes, every unit after the first waits for the gap. bus_req rises GAP+2 cycles after the last write cycle of the previous unit, where GAP is 16 or 64 and req_n is low.
- R9: The gap counter restarts from zero for each unit. Toggling req_n during the gap neither shortens nor lengthens it.
- R10: In burst mode the bus is held across unit boundaries while req_n is low. If req_n is high at a unit boundary, bus_req drops the next cycle and the transfer resumes when req_n returns low.
- R11: After the last counted unit, done rises and stays high. bus_req is not raised again, even with req_n low.
- R12: A start pulse, mode, size or count applied while the channel is active has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load configuration and arm (honoured only when idle) |
| cfg_mode | input | 2 | Bus mode select |
| cfg_size | input | 2 | Transfer-unit size select |
| cfg_count | input | CNT_W | Number of units to move |
| req_n | input | 1 | Active-low level transfer request |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus mastership request / hold |
| rd_stb | output | 1 | Read bus cycle strobe |
| wr_stb | output | 1 | Write bus cycle strobe |
| done | output | 1 | Terminal count reached (sticky until next start) |

## Verification
Every output comes straight from a registered state, so each result appears one clock after the input that causes it. Inputs are driven and outputs sampled on the falling edge, which makes the cycle counts simple to follow. For a single-beat unit started with the request low and the grant high, bus_req is seen on the 2nd sample, rd_stb on the 3rd, wr_stb on the 4th and done on the 5th. A throttled unit adds one arm cycle plus the gap, so bus_req is seen exactly GAP+2 samples after the previous write. The table-driven runs compare the total cycles, the strobe counts and the number of bus_req rises against closed-form counts for each mode and size. The directed runs check the exact sample at which each event appears.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [1:0] {
    MODE_BURST = 2'd0,
    MODE_STEAL = 2'd1,
    MODE_GAP16 = 2'd2,
    MODE_GAP64 = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    UNIT_BYTE    = 2'd0,
    UNIT_WORD    = 2'd1,
    UNIT_LONG    = 2'd2,
    UNIT_BLOCK16 = 2'd3
  } unit_size_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_GAP  = 3'd2,
    ST_REQ  = 3'd3,
    ST_RD   = 3'd4,
    ST_WR   = 3'd5
  } seq_state_e;

  // read/write pairs needed to move one unit
  function automatic logic [2:0] beats_per_unit(unit_size_e s);
    return (s == UNIT_BLOCK16) ? 3'd4 : 3'd1;
  endfunction

  function automatic logic is_throttled(bus_mode_e m);
    return (m == MODE_GAP16) || (m == MODE_GAP64);
  endfunction

endpackage

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  localparam int GAP_W    = $clog2(GAP_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_gap,
  output logic expire
);
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] limit;

  assign limit  = long_gap ? GAP_W'(GAP_LONG - 1) : GAP_W'(GAP_SHORT - 1);
  assign expire = run && (cnt_q == limit);

  // counter is cleared whenever the wait is not running, so every unit starts at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  AST_GAP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));  // R9
  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));  // R8
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remaining_q;

  assign last = (remaining_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remaining_q <= '0;
    else if (load)  remaining_q <= load_val;
    else if (dec)   remaining_q <= remaining_q - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (remaining_q != '0));  // R11
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_steal_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_size,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_n,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);
  seq_state_e state_q, state_d;
  bus_mode_e  mode_q;
  unit_size_e size_q;
  logic [2:0] beat_q;
  logic       first_q;
  logic       done_q;

  // named internal events
  logic start_ok, req_seen, beat_last, unit_end, cnt_last, gap_run, gap_expire, zero_load;

  assign start_ok  = start && (state_q == ST_IDLE);
  assign zero_load = start_ok && (cfg_count == '0);
  assign req_seen  = !req_n;
  assign beat_last = (beat_q == (beats_per_unit(size_q) - 3'd1));
  assign unit_end  = (state_q == ST_WR) && beat_last;
  assign gap_run   = (state_q == ST_GAP);

  dma_unit_counter #(.CNT_W(CNT_W)) u_units (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (cfg_count),
    .dec      (unit_end),
    .last     (cnt_last)
  );

  dma_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gap_run),
    .long_gap (mode_q == MODE_GAP64),
    .expire   (gap_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok && !zero_load) state_d = ST_ARM;
      ST_ARM:  if (req_seen) state_d = (is_throttled(mode_q) && !first_q) ? ST_GAP : ST_REQ;
      ST_GAP:  if (gap_expire) state_d = ST_REQ;
      ST_REQ:  if (bus_gnt) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        if (!beat_last)                            state_d = ST_RD;
        else if (cnt_last)                         state_d = ST_IDLE;
        else if (mode_q == MODE_BURST && req_seen) state_d = ST_RD;
        else                                       state_d = ST_ARM;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_BURST;
      size_q  <= UNIT_BYTE;
      beat_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        mode_q  <= bus_mode_e'(cfg_mode);
        size_q  <= unit_size_e'(cfg_size);
        beat_q  <= '0;
        first_q <= 1'b1;
        done_q  <= zero_load;
      end else begin
        if (state_q == ST_WR) beat_q <= beat_last ? 3'd0 : beat_q + 3'd1;
        if (unit_end) first_q <= 1'b0;
        if (unit_end && cnt_last) done_q <= 1'b1;
      end
    end
  end

  assign bus_req = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
  assign rd_stb  = (state_q == ST_RD);
  assign wr_stb  = (state_q == ST_WR);
  assign done    = done_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));  // R5
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> wr_stb);  // R5
  AST_STROBE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> bus_req);  // R5
  AST_NO_RD_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && !bus_gnt) |=> (bus_req && !rd_stb));  // R4
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);  // R11
  AST_ARM_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && req_n) |=> !bus_req);  // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(size_q)));  // R12
endmodule

// File: tb/sim_dma_steal_seq.sv
`timescale 1ns/1ps
module sim_dma_steal_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_n = 1'b1, bus_gnt = 1'b1;
  logic [1:0] cfg_mode = '0, cfg_size = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic bus_req, rd_stb, wr_stb, done;

  int errors = 0, checks = 0, wd = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_steal_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_count(cfg_count), .req_n(req_n), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {mode, size, count}
  localparam logic [11:0] VEC [8] = '{
    {2'd1, 2'd0, 8'd1}, {2'd1, 2'd1, 8'd3}, {2'd0, 2'd2, 8'd4}, {2'd0, 2'd3, 8'd2},
    {2'd2, 2'd0, 8'd3}, {2'd3, 2'd3, 8'd2}, {2'd1, 2'd3, 8'd2}, {2'd2, 2'd2, 8'd1}
  };

  function automatic int beats_of(input int sz);
    return (sz == 3) ? 4 : 1;
  endfunction

  // falling-edge samples from the start sample up to the one showing done
  function automatic int exp_cycles(input int md, input int sz, input int n);
    int b = beats_of(sz);
    int g = (md == 2) ? 16 : (md == 3) ? 64 : 0;
    if (md == 0) return 1 + 2 + n * 2 * b;
    return 1 + n * (2 + 2 * b) + (n - 1) * g;
  endfunction

  task automatic kick(input int md, input int sz, input int n);
    @(negedge clk);
    cfg_mode = 2'(md); cfg_size = 2'(sz); cfg_count = CNT_W'(n); start = 1'b1;
  endtask

  initial begin
    int cyc, rds, wrs, rises, k;
    bit prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !rd_stb && !wr_stb && !done, "R1 reset outputs",
          {bus_req, rd_stb, wr_stb, done}, 0);

    // table-driven runs: request low, grant high
    req_n = 1'b0;
    foreach (VEC[i]) begin
      int md = int'(VEC[i][11:10]);
      int sz = int'(VEC[i][9:8]);
      int n  = int'(VEC[i][7:0]);
      string ctag = (md == 0) ? "R10 burst cycles" : (md == 1) ? "R7 normal cycles" : "R8 gap cycles";
      kick(md, sz, n);
      cyc = 0; rds = 0; wrs = 0; rises = 0; prev = 1'b0;
      do begin
        @(negedge clk);
        start = 1'b0;
        cyc++;
        rds += int'(rd_stb); wrs += int'(wr_stb);
        if (bus_req && !prev) rises++;
        prev = bus_req;
      end while (!done && cyc < 2000);
      check(cyc == exp_cycles(md, sz, n), ctag, cyc, exp_cycles(md, sz, n));
      check(rds == n * beats_of(sz), "R6 read beats", rds, n * beats_of(sz));
      check(wrs == n * beats_of(sz), "R5 write beats", wrs, n * beats_of(sz));
      check(rises == ((md == 0) ? 1 : n), "R7 bus_req assertions", rises, (md == 0) ? 1 : n);
    end

    // R2 / R11: zero count finishes at once, no bus request afterwards
    kick(1, 0, 0);
    @(negedge clk); start = 1'b0;
    check(done && !bus_req, "R2 zero count done", {done, bus_req}, 2);
    rises = 0;
    repeat (6) begin @(negedge clk); rises += int'(bus_req); end
    check(rises == 0 && done, "R11 no request after done", rises, 0);

    // R3 / R4: request held off, then a delayed grant
    req_n = 1'b1; bus_gnt = 1'b0;
    kick(1, 0, 1);
    @(negedge clk); start = 1'b0;
    rises = 0;
    repeat (8) begin @(negedge clk); rises += int'(bus_req); end
    check(rises == 0, "R3 high req_n holds off bus_req", rises, 0);
    req_n = 1'b0;
    @(negedge clk);
    check(bus_req, "R4 bus_req one cycle after request", bus_req, 1);
    rds = 0; k = 0;
    repeat (5) begin @(negedge clk); rds += int'(rd_stb); k += int'(bus_req); end
    check(rds == 0 && k == 5, "R4 wait for grant", rds, 0);
    bus_gnt = 1'b1;
    @(negedge clk);
    check(rd_stb, "R4 read after grant", rd_stb, 1);
    @(negedge clk);
    check(wr_stb && !rd_stb, "R5 write follows read", wr_stb, 1);
    @(negedge clk);
    check(done, "R11 done after last unit", done, 1);

    // R12: start and config changes while active are ignored
    kick(1, 0, 2);
    @(negedge clk);
    cfg_mode = 2'd0; cfg_count = 8'd7; cfg_size = 2'd3;  // start still high: ignored
    rds = 0; rises = 0; prev = bus_req; cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      rds += int'(rd_stb);
      if (bus_req && !prev) rises++;
      prev = bus_req;
    end while (!done && cyc < 500);
    check(rds == 2, "R12 count unchanged while active", rds, 2);
    check(rises == 2, "R12 mode unchanged while active", rises, 2);

    // R10: burst released when request is high at a unit boundary
    kick(0, 0, 3);
    @(negedge clk); start = 1'b0;
    rds = 0; cyc = 0;
    while (!wr_stb && cyc < 50) begin @(negedge clk); cyc++; rds += int'(rd_stb); end
    req_n = 1'b1;
    @(negedge clk);
    check(!bus_req, "R10 release on high request", bus_req, 0);
    repeat (3) @(negedge clk);
    check(!bus_req, "R10 stays released", bus_req, 0);
    req_n = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; rds += int'(rd_stb); end while (!done && cyc < 100);
    check(rds == 3, "R10 resumes to terminal count", rds, 3);

    // R9: gap not shortened by request toggling
    kick(2, 0, 2);
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!wr_stb && cyc < 50) begin @(negedge clk); cyc++; end
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 3) req_n = 1'b1;
      if (k == 6) req_n = 1'b0;
    end while (!bus_req && k < 200);
    check(k == 18, "R9 gap length with toggling", k, 18);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!done && cyc < 100);
    check(done, "R11 throttled run completes", done, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule